// File: doc/BRIEF.md
# E1 Time Slot 16 Signaling Buffer

This block sits beside an E1 framer datapath and carries per-channel signaling between the line and a host processor. Each of the sixteen frames of a multiframe carries one signaling byte in time slot 16. The receive side collects these bytes into a staging area as they arrive. It hands the complete set to the host only when the next multiframe starts, so the host never sees a set that mixes two multiframes.

The transmit side keeps a host-written copy of the sixteen outgoing signaling bytes. At every multiframe start it copies them into a shift stage. During the following multiframe that stage replaces time slot 16 of each outgoing frame, if insertion is enabled. One register address serves both directions: a read returns received signaling, and a write loads transmit signaling. A readback control bit redirects reads to the transmit copy. For channel-associated signaling, the host keeps the upper nibble of the frame-0 byte at zero so that it forms the multiframe alignment pattern. The block stores and sends this byte like any other.

Two sticky status flags tell the host when fresh receive data has arrived and when a transmit multiframe has begun. The host then has one multiframe (2 ms) to read or refresh the bytes. The stream runs at one bit per clock. A frame is 256 bits, numbered from the frame sync strobe, and time slot 16 occupies bits 128 to 135.

Top module: `e1_sig_buffer`

## Requirements
- R1: After reset, both status flags are 0. Every receive register reads 0x00, and the transmit output equals the transmit input.
- R2: When the stream is aligned, bits 128..135 of frame k (k = 0..15, bit 0 being the frame sync cycle) form one byte, MSB first. After the transfer (R3), that byte reads at host address k.
- R3: Receive registers change only in the cycle after a receive multiframe strobe that follows an earlier multiframe strobe. That transfer sets the receive flag (`stat_rx_new`). The flag is not set at any other time.
- R4: A host write to address k loads transmit byte k. While `cfg_tx_readback` is 1, a read of address k returns transmit byte k instead of receive data.
- R5: While `cfg_tx_insert` is 1 and the transmit side is aligned, bits 128..135 of transmit frame k carry shift byte k, MSB first. All other bits equal `tx_data_in`.
- R6: While `cfg_tx_insert` is 0, `tx_data_out` equals `tx_data_in` in every cycle.
- R7: The shift bytes are loaded from the transmit bytes only on a transmit multiframe strobe. A write during a multiframe, including one in the strobe cycle itself, reaches the line only in the next multiframe.
- R8: Every transmit multiframe strobe sets the transmit flag (`stat_tx_mf`).
- R9: Each flag stays set until its clear bit is 1: `stat_clr[1]` clears the receive flag and `stat_clr[0]` clears the transmit flag. When a set and a clear fall in the same cycle, the set wins.
- R10: Before the first multiframe strobe on a side, that side captures nothing, inserts nothing and raises no flag, even if frame strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one stream bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Receive serial bit |
| rx_frame_sync | input | 1 | High on bit 0 of each receive frame |
| rx_mf_sync | input | 1 | High on bit 0 of receive frame 0 |
| tx_data_in | input | 1 | Transmit serial bit from the framer |
| tx_frame_sync | input | 1 | High on bit 0 of each transmit frame |
| tx_mf_sync | input | 1 | High on bit 0 of transmit frame 0 |
| tx_data_out | output | 1 | Transmit serial bit with signaling inserted |
| host_addr | input | 4 | Signaling byte index 0..15 |
| host_wr | input | 1 | Write strobe for the transmit byte |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational on address |
| cfg_tx_readback | input | 1 | 1: reads return transmit bytes |
| cfg_tx_insert | input | 1 | 1: drive time slot 16 from the shift stage |
| stat_rx_new | output | 1 | Sticky: new receive signaling available |
| stat_tx_mf | output | 1 | Sticky: transmit multiframe started |
| stat_clr | input | 2 | Write-1 clears: bit 1 receive flag, bit 0 transmit flag |

## Verification
Properties checked on every cycle:
- Pass-through when insertion is off, and outside time slot 16.
- Flags set after each transfer or strobe, and stay held or cleared as the clear bits say.
- Host read data stays stable between receive boundaries.
- Alignment persists once gained.

Only the bench scenarios can show the content-level behaviour:
- The correct byte lands at the correct index, MSB first.
- The data shows one multiframe of delay.
- A mid-multiframe write stays off the line until the next boundary, and a write in the strobe cycle misses the load.
- Readback returns the transmit bytes.
- Nothing is inserted while frame strobes run without a multiframe strobe.

// File: rtl/e1sig_pkg.sv
package e1sig_pkg;

    localparam int SLOTS      = 32;
    localparam int SLOT_BITS  = 8;
    localparam int FRAMES     = 16;
    localparam int SIG_SLOT   = 16;
    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int FRM_W      = $clog2(FRAMES);
    localparam int BIT_W      = $clog2(SLOT_BITS);
    localparam int SIG_START  = SIG_SLOT * SLOT_BITS;
    localparam int SIG_END    = SIG_START + SLOT_BITS;

    typedef logic [SLOT_BITS-1:0] sig_byte_t;
    typedef sig_byte_t [FRAMES-1:0] sig_set_t;

    // Where the stream is in the current cycle
    typedef struct packed {
        logic             aligned;   // a multiframe strobe has been seen (incl. now)
        logic             primed;    // a multiframe strobe was seen before this cycle
        logic             boundary;  // this cycle is bit 0 of frame 0
        logic             in_sig;    // this bit belongs to time slot 16
        logic [FRM_W-1:0] frame;
        logic [BIT_W-1:0] bit_sel;   // MSB-first bit index inside the slot byte
    } stream_pos_t;

    function automatic logic in_sig_slot(input logic [POS_W-1:0] p);
        return (p >= POS_W'(SIG_START)) && (p < POS_W'(SIG_END));
    endfunction

    function automatic logic [BIT_W-1:0] msb_index(input logic [POS_W-1:0] p);
        logic [POS_W-1:0] off;
        off = p - POS_W'(SIG_START);
        return BIT_W'(SLOT_BITS - 1) - off[BIT_W-1:0];
    endfunction

endpackage

// File: rtl/e1sig_frame_track.sv
module e1sig_frame_track
    import e1sig_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_sync,
    input  logic        mf_sync,
    output stream_pos_t where
);

    logic [POS_W-1:0] pos_q, pos_now;
    logic [FRM_W-1:0] frm_q, frm_now;
    logic             aligned_q, aligned_now;

    always_comb begin
        pos_now     = (frame_sync | mf_sync) ? '0 : pos_q + 1'b1;
        frm_now     = mf_sync ? '0 : (frame_sync ? frm_q + 1'b1 : frm_q);
        aligned_now = aligned_q | mf_sync;

        where.aligned  = aligned_now;
        where.primed   = aligned_q;
        where.boundary = mf_sync;
        where.in_sig   = aligned_now & in_sig_slot(pos_now);
        where.frame    = frm_now;
        where.bit_sel  = msb_index(pos_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            frm_q     <= '0;
            aligned_q <= 1'b0;
        end else begin
            pos_q     <= pos_now;
            frm_q     <= frm_now;
            aligned_q <= aligned_now;
        end
    end

    AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
        aligned_q |=> aligned_q); // R10

    AST_NO_SIG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        mf_sync |-> !where.in_sig); // R2

endmodule

// File: rtl/e1sig_rx_capture.sv
module e1sig_rx_capture
    import e1sig_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stream_pos_t where,
    input  logic        rx_bit,
    output sig_set_t    host_set,
    output logic        xfer
);

    sig_set_t stage_q;
    sig_set_t host_q;

    assign xfer     = where.boundary & where.primed;
    assign host_set = host_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            host_q  <= '0;
        end else begin
            if (where.in_sig)
                stage_q[where.frame] <= {stage_q[where.frame][SLOT_BITS-2:0], rx_bit};
            if (xfer)
                host_q <= stage_q;
        end
    end

    AST_RX_XFER_ONLY_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        xfer |-> where.aligned); // R10

    AST_RX_HOST_HELD: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(host_q)); // R3

endmodule

// File: rtl/e1sig_tx_insert.sv
module e1sig_tx_insert
    import e1sig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  stream_pos_t      where,
    input  logic             wr_en,
    input  logic [FRM_W-1:0] wr_idx,
    input  sig_byte_t        wr_data,
    input  logic             insert_en,
    input  logic             tx_in,
    output sig_set_t         held_set,
    output logic             tx_out
);

    sig_set_t held_q;
    sig_set_t shift_q;

    assign held_set = held_q;
    assign tx_out   = (insert_en & where.in_sig) ? shift_q[where.frame][where.bit_sel] : tx_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            shift_q <= '0;
        end else begin
            if (where.boundary)
                shift_q <= held_q;
            if (wr_en)
                held_q[wr_idx] <= wr_data;
        end
    end

    AST_TX_PASS_OFF: assert property (@(posedge clk) disable iff (rst)
        !insert_en |-> (tx_out == tx_in)); // R6

    AST_TX_PASS_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        !where.in_sig |-> (tx_out == tx_in)); // R5

    AST_TX_SHIFT_HELD: assert property (@(posedge clk) disable iff (rst)
        !where.boundary |=> $stable(shift_q)); // R7

endmodule

// File: rtl/e1_sig_buffer.sv
module e1_sig_buffer
    import e1sig_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_data,
    input  logic                 rx_frame_sync,
    input  logic                 rx_mf_sync,
    input  logic                 tx_data_in,
    input  logic                 tx_frame_sync,
    input  logic                 tx_mf_sync,
    output logic                 tx_data_out,
    input  logic [FRM_W-1:0]     host_addr,
    input  logic                 host_wr,
    input  logic [SLOT_BITS-1:0] host_wdata,
    output logic [SLOT_BITS-1:0] host_rdata,
    input  logic                 cfg_tx_readback,
    input  logic                 cfg_tx_insert,
    output logic                 stat_rx_new,
    output logic                 stat_tx_mf,
    input  logic [1:0]           stat_clr
);

    stream_pos_t rx_where, tx_where;
    sig_set_t    rx_set, tx_set;
    logic        rx_xfer;
    logic        rx_new_q, tx_mf_q;

    e1sig_frame_track u_rx_track (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (rx_frame_sync),
        .mf_sync    (rx_mf_sync),
        .where      (rx_where)
    );

    e1sig_frame_track u_tx_track (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (tx_frame_sync),
        .mf_sync    (tx_mf_sync),
        .where      (tx_where)
    );

    e1sig_rx_capture u_rx (
        .clk      (clk),
        .rst      (rst),
        .where    (rx_where),
        .rx_bit   (rx_data),
        .host_set (rx_set),
        .xfer     (rx_xfer)
    );

    e1sig_tx_insert u_tx (
        .clk       (clk),
        .rst       (rst),
        .where     (tx_where),
        .wr_en     (host_wr),
        .wr_idx    (host_addr),
        .wr_data   (host_wdata),
        .insert_en (cfg_tx_insert),
        .tx_in     (tx_data_in),
        .held_set  (tx_set),
        .tx_out    (tx_data_out)
    );

    // One address, two directions: reads follow the readback bit
    assign host_rdata = cfg_tx_readback ? tx_set[host_addr] : rx_set[host_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_new_q <= 1'b0;
            tx_mf_q  <= 1'b0;
        end else begin
            rx_new_q <= rx_xfer | (rx_new_q & ~stat_clr[1]);
            tx_mf_q  <= tx_where.boundary | (tx_mf_q & ~stat_clr[0]);
        end
    end

    assign stat_rx_new = rx_new_q;
    assign stat_tx_mf  = tx_mf_q;

    AST_RX_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        rx_xfer |=> stat_rx_new); // R3

    AST_TX_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        tx_mf_sync |=> stat_tx_mf); // R8

    AST_TX_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat_tx_mf && !stat_clr[0]) |=> stat_tx_mf); // R9

    AST_RX_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_clr[1] && !rx_mf_sync) |=> !stat_rx_new); // R9

    AST_RX_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!rx_mf_sync && !cfg_tx_readback) ##1 (!cfg_tx_readback && $stable(host_addr))
        |-> $stable(host_rdata)); // R3

endmodule

// File: tb/sim_e1_sig_buffer.sv
module sim_e1_sig_buffer;
    import e1sig_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       rx_data, rx_frame_sync, rx_mf_sync;
    logic       tx_data_in, tx_frame_sync, tx_mf_sync, tx_data_out;
    logic [3:0] host_addr;
    logic       host_wr;
    logic [7:0] host_wdata, host_rdata;
    logic       cfg_tx_readback, cfg_tx_insert;
    logic       stat_rx_new, stat_tx_mf;
    logic [1:0] stat_clr;

    e1_sig_buffer u0 (.*);

    int checks = 0;
    int fails  = 0;
    logic [7:0] tx_model [16];
    logic [7:0] shift_model [16];
    bit tb_aligned = 0;

    function automatic logic [7:0] rxpat(int m, int k);
        return 8'((m * 37 + k * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] txpat(int m, int k);
        return 8'((m * 53 + k * 19 + 3) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", req, act, exp, $time);
        end
    endtask

    // One stream bit: drive at negedge, check after settling
    task automatic step(int m, int g, bit strobes);
        int pos, frame;
        logic [7:0] b;
        logic exp_out;
        pos   = g % 256;
        frame = g / 256;
        @(negedge clk);
        rx_frame_sync = (pos == 0);
        tx_frame_sync = (pos == 0);
        rx_mf_sync    = strobes && (g == 0);
        tx_mf_sync    = strobes && (g == 0);
        if (pos >= 128 && pos < 136) begin
            b = rxpat(m, frame);
            rx_data = b[7 - (pos - 128)];
        end else begin
            rx_data = ((pos * 3 + frame) >> 1) & 1;
        end
        tx_data_in = ^(8'(pos) ^ 8'(frame * 5));
        if (strobes && g == 0) begin
            tb_aligned = 1;
            for (int k = 0; k < 16; k++) shift_model[k] = tx_model[k];
            cfg_tx_insert = (m >= 1);
        end
        // host write port
        host_wr = 0;
        if (g >= 1000 && g < 1016 && m < 4) begin
            host_wr = 1; host_addr = 4'(g - 1000); host_wdata = txpat(m + 1, g - 1000);
        end
        if (m == 2 && g == 0) begin
            host_wr = 1; host_addr = 4'd5; host_wdata = 8'hA5; // R7 write in strobe cycle
        end
        if (m == -1 && g >= 20 && g < 36) begin
            host_wr = 1; host_addr = 4'(g - 20); host_wdata = txpat(0, g - 20);
        end
        stat_clr = 2'b00;
        if (g == 10) stat_clr = 2'b11;
        if (m == 3 && g == 0) stat_clr = 2'b11;
        // read address sweeps
        cfg_tx_readback = (g >= 3000 && g < 3016);
        if (g >= 2000 && g < 2016) host_addr = 4'(g - 2000);
        if (g >= 3000 && g < 3016) host_addr = 4'(g - 3000);
        if (m == -1 && g >= 100 && g < 116) host_addr = 4'(g - 100);
        #1;
        if (cfg_tx_insert && tb_aligned && pos >= 128 && pos < 136) begin
            b = shift_model[frame];
            exp_out = b[7 - (pos - 128)];
            chk(tx_data_out == exp_out, "R5 slot16 insert", tx_data_out, exp_out);
        end else if (!cfg_tx_insert) begin
            chk(tx_data_out == tx_data_in, "R6 passthrough", tx_data_out, tx_data_in);
        end else if (!tb_aligned) begin
            chk(tx_data_out == tx_data_in, "R10 no insert before mf strobe", tx_data_out, tx_data_in);
        end else begin
            chk(tx_data_out == tx_data_in, "R5 other bits pass", tx_data_out, tx_data_in);
        end
        if (m == -1 && g >= 100 && g < 116) begin
            chk(host_rdata == 8'h00, "R10 rx registers unchanged before alignment", host_rdata, 0);
            chk(stat_rx_new == 0 && stat_tx_mf == 0, "R10 flags idle before alignment",
                {stat_rx_new, stat_tx_mf}, 0);
        end
        if (m >= 0 && g == 5) begin
            chk(stat_tx_mf == 1, "R8 tx flag at mf strobe", stat_tx_mf, 1);
            chk(stat_rx_new == (m >= 1), "R3 rx flag only after a full multiframe",
                stat_rx_new, (m >= 1));
            if (m == 3) chk(stat_tx_mf == 1, "R9 set wins over clear", stat_tx_mf, 1);
        end
        if (m >= 0 && g == 12)
            chk(stat_rx_new == 0 && stat_tx_mf == 0, "R9 write-1 clear",
                {stat_rx_new, stat_tx_mf}, 0);
        if (m >= 0 && g == 2000)
            chk(stat_rx_new == 0, "R3 no rx flag mid multiframe", stat_rx_new, 0);
        if (m >= 0 && g >= 2000 && g < 2016) begin
            b = (m >= 1) ? rxpat(m - 1, g - 2000) : 8'h00;
            chk(host_rdata == b, "R2 rx byte at index", host_rdata, b);
        end
        if (m >= 0 && g >= 3000 && g < 3016) begin
            b = tx_model[g - 3000];
            chk(host_rdata == b, "R4 tx readback", host_rdata, b);
        end
        if (host_wr) tx_model[host_addr] = host_wdata;
    endtask

    initial begin
        rst = 1;
        rx_data = 0; rx_frame_sync = 0; rx_mf_sync = 0;
        tx_data_in = 1; tx_frame_sync = 0; tx_mf_sync = 0;
        host_addr = 0; host_wr = 0; host_wdata = 0;
        cfg_tx_readback = 0; cfg_tx_insert = 1; stat_clr = 0;
        for (int k = 0; k < 16; k++) begin tx_model[k] = 0; shift_model[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk(stat_rx_new == 0 && stat_tx_mf == 0, "R1 flags after reset", {stat_rx_new, stat_tx_mf}, 0);
        chk(host_rdata == 8'h00, "R1 rx register after reset", host_rdata, 0);
        chk(tx_data_out == tx_data_in, "R1 tx passthrough after reset", tx_data_out, tx_data_in);
        // frame strobes without any multiframe strobe, insertion requested
        for (int g = 0; g < 300; g++) step(-1, g, 0);
        cfg_tx_insert = 0;
        for (int m = 0; m < 5; m++)
            for (int g = 0; g < 4096; g++) step(m, g, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule